// File: doc/BRIEF.md
# Pen Palette Fetcher with Page-Break-Safe Termination

This block loads an eight-byte pen palette from byte-wide memory into a sixteen-entry map of 4-bit pen indices. A one-cycle start pulse captures a 16-bit base address. The block then reads the eight consecutive bytes through a request/valid read port. Each byte fills two neighbouring pen entries. The resulting map is presented in parallel to the sprite pipeline.

The memory side may stall for any number of cycles. It stalls longer whenever a read steps over a 256-byte page boundary. The loader raises an early-end indication when two bytes remain to be read, and it uses that indication to switch into a short tail phase. If that indication would fall in the same cycle as a page crossing, the loader moves it one cycle later. This keeps the tail phase from being lost, so a palette whose base sits at page offset 0xFA still loads all eight bytes, including the last four pens.

Top module: `penmap_loader`

## Requirements
- R1: A start pulse while idle captures `baseAddr`; in the next cycle `memReq` is high and `memAddr` equals the captured base.
- R2: Each cycle with `memReq` and `memValid` both high accepts one byte and advances `memAddr` by one; exactly eight bytes are accepted per load.
- R3: Byte n of the palette (n = 0..7) writes pen 2n from its bits 7:4 and pen 2n+1 from its bits 3:0; pen k appears on `penMap` bits 4k+3 down to 4k.
- R4: When the sixth byte is accepted from an address whose low eight bits are not 0xFF, `endEarly` is high for exactly one cycle, in the cycle after that acceptance.
- R5: When the sixth byte comes from an address whose low eight bits are 0xFF (a page crossing follows), `endEarly` is high for exactly one cycle, two cycles after that acceptance.
- R6: A load whose base lies at page offset 0xFA replaces all sixteen pens, including pens 12 to 15, with the new palette's values.
- R7: `done` is high for exactly one cycle, in the cycle after the eighth byte is accepted, and `memReq` is low in that cycle.
- R8: A start pulse during a load is ignored: the address sequence and the final pen map are those of the load already under way.
- R9: Synchronous active-high reset clears every pen to 0, drops `memReq`, `done` and `endEarly`, and returns the loader to idle, including in the middle of a load.
- R10: While `memReq` is high and `memValid` is low, `memAddr` holds its value, whatever the length of the stall.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle load request |
| baseAddr | input | 16 | Palette base address, captured on start |
| memReq | output | 1 | Read request, held until a byte is returned |
| memAddr | output | 16 | Address of the byte being requested |
| memValid | input | 1 | Read data valid for the current address |
| memData | input | 8 | Read data byte |
| penMap | output | 64 | Sixteen 4-bit pens, pen k at bits 4k+3:4k |
| endEarly | output | 1 | Pulse: two bytes remain to be read |
| done | output | 1 | Pulse: all eight bytes are written |

## Verification
All outputs come from registers. The request and address appear one cycle after start. `done` follows the eighth valid byte by one cycle, and `endEarly` follows the sixth valid byte by one cycle, or by two when that byte is the last of its page. The bench samples on the falling edge and records the cycle numbers of the sixth valid byte, the eighth valid byte, `endEarly` and `done`. It then compares the gaps between those cycle numbers with these exact values, so the checks do not depend on the memory model's stall lengths. The memory model stalls two extra cycles on every page crossing.

// File: rtl/penmap_pkg.sv
package penmap_pkg;
  localparam int BYTE_COUNT = 8;
  localparam int PEN_W      = 4;
  localparam int PEN_COUNT  = 2 * BYTE_COUNT;
  localparam int SLOT_W     = $clog2(BYTE_COUNT);
  localparam int END_LEAD   = 2;
  localparam int END_SLOT   = BYTE_COUNT - END_LEAD - 1;

  typedef struct packed {
    logic              loadBase;
    logic              writeByte;
    logic [SLOT_W-1:0] slot;
  } ctrlStrobes_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_TAIL  = 2'd2
  } loadState_t;
endpackage

// File: rtl/penmap_ctrl.sv
module penmap_ctrl
  import penmap_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic         memValid,
  input  logic         pageLast,
  output logic         memReq,
  output ctrlStrobes_t strobes,
  output logic         endEarly,
  output logic         done
);
  localparam int REM_W = $clog2(END_LEAD + 1);

  loadState_t        state;
  logic [SLOT_W-1:0] slotQ;
  logic [REM_W-1:0]  remainQ;
  logic              endLate;
  logic              accept;

  assign accept = memValid && (state != ST_IDLE);
  assign memReq = (state != ST_IDLE);

  always_comb begin
    strobes.loadBase  = (state == ST_IDLE) && start;
    strobes.writeByte = accept;
    strobes.slot      = slotQ;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      slotQ    <= '0;
      remainQ  <= '0;
      endLate  <= 1'b0;
      endEarly <= 1'b0;
      done     <= 1'b0;
    end else begin
      done     <= 1'b0;
      endEarly <= endLate;
      endLate  <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            state <= ST_FETCH;
            slotQ <= '0;
          end
        end
        ST_FETCH: begin
          if (endLate) begin
            // deferred end: enter the tail one cycle after the page crossing
            state   <= ST_TAIL;
            remainQ <= REM_W'(END_LEAD);
          end
          if (accept) begin
            slotQ <= slotQ + 1'b1;
            if (slotQ == SLOT_W'(END_SLOT)) begin
              if (pageLast) begin
                endLate <= 1'b1;
              end else begin
                endEarly <= 1'b1;
                state    <= ST_TAIL;
                remainQ  <= REM_W'(END_LEAD);
              end
            end
          end
        end
        ST_TAIL: begin
          if (accept) begin
            slotQ   <= slotQ + 1'b1;
            remainQ <= remainQ - 1'b1;
            if (remainQ == REM_W'(1)) begin
              state <= ST_IDLE;
              done  <= 1'b1;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/penmap_dp.sv
module penmap_dp
  import penmap_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int PAGE_BITS = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [ADDR_W-1:0]          baseAddr,
  input  ctrlStrobes_t               strobes,
  input  logic [2*PEN_W-1:0]         memData,
  output logic [ADDR_W-1:0]          memAddr,
  output logic                       pageLast,
  output logic [PEN_COUNT*PEN_W-1:0] penMap
);
  localparam int BYTE_W = 2 * PEN_W;

  logic [ADDR_W-1:0] addrQ;

  always_ff @(posedge clk) begin
    if (rst)                    addrQ <= '0;
    else if (strobes.loadBase)  addrQ <= baseAddr;
    else if (strobes.writeByte) addrQ <= addrQ + 1'b1;
  end

  assign memAddr  = addrQ;
  assign pageLast = &addrQ[PAGE_BITS-1:0];

  for (genvar g = 0; g < BYTE_COUNT; g++) begin : g_slot
    logic [PEN_W-1:0] penEven;
    logic [PEN_W-1:0] penOdd;
    always_ff @(posedge clk) begin
      if (rst) begin
        penEven <= '0;
        penOdd  <= '0;
      end else if (strobes.writeByte && strobes.slot == SLOT_W'(g)) begin
        penEven <= memData[BYTE_W-1:PEN_W];
        penOdd  <= memData[PEN_W-1:0];
      end
    end
    assign penMap[g*BYTE_W +: BYTE_W] = {penOdd, penEven};
  end
endmodule

// File: rtl/penmap_loader.sv
module penmap_loader
  import penmap_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  input  logic [15:0] baseAddr,
  output logic        memReq,
  output logic [15:0] memAddr,
  input  logic        memValid,
  input  logic [7:0]  memData,
  output logic [63:0] penMap,
  output logic        endEarly,
  output logic        done
);
  ctrlStrobes_t strobes;
  logic         pageLast;

  penmap_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .memValid (memValid),
    .pageLast (pageLast),
    .memReq   (memReq),
    .strobes  (strobes),
    .endEarly (endEarly),
    .done     (done)
  );

  penmap_dp #(.ADDR_W(16), .PAGE_BITS(8)) u_dp (
    .clk      (clk),
    .rst      (rst),
    .baseAddr (baseAddr),
    .strobes  (strobes),
    .memData  (memData),
    .memAddr  (memAddr),
    .pageLast (pageLast),
    .penMap   (penMap)
  );
endmodule

// File: rtl/penmap_loader_chk.sv
module penmap_loader_chk (
  input logic        clk,
  input logic        rst,
  input logic        start,
  input logic        memReq,
  input logic [15:0] memAddr,
  input logic        memValid,
  input logic [63:0] penMap,
  input logic        endEarly,
  input logic        done
);
  p_reset_clear_r9: assert property (@(posedge clk)
    rst |=> (penMap == 64'd0 && !done && !memReq && !endEarly));

  p_addr_step_r2: assert property (@(posedge clk) disable iff (rst)
    (memReq && memValid) |=> memAddr == $past(memAddr) + 16'd1);

  p_addr_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (memReq && !memValid) |=> $stable(memAddr));

  p_end_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    endEarly |=> !endEarly);

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_done_idle_r7: assert property (@(posedge clk) disable iff (rst)
    done |-> !memReq);

  p_start_busy_r8: assert property (@(posedge clk) disable iff (rst)
    (memReq && start && !memValid) |=> memReq);
endmodule

bind penmap_loader penmap_loader_chk u_chk (.*);

// File: tb/penmap_loader_test.sv
module penmap_loader_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [15:0] baseAddr = 16'h0;
  logic        memReq;
  logic [15:0] memAddr;
  logic        memValid = 1'b0;
  logic [7:0]  memData = 8'h0;
  logic [63:0] penMap;
  logic        endEarly;
  logic        done;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  penmap_loader uut (.*);

  function automatic logic [7:0] fdata(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A ^ {a[2:0], 5'b0};
  endfunction

  function automatic logic [63:0] expMap(input logic [15:0] b);
    logic [63:0] m;
    for (int n = 0; n < 8; n++) begin
      logic [7:0] d;
      d = fdata(b + 16'(n));
      m[n*8 +: 8] = {d[3:0], d[7:4]};
    end
    return m;
  endfunction

  // memory model: 1 wait cycle per byte, 2 more on a page crossing
  logic       armed = 1'b0;
  logic [1:0] stall = 2'd0;
  logic [7:0] prevLow = 8'h0;
  logic       havePrev = 1'b0;
  always @(posedge clk) begin
    memValid <= 1'b0;
    if (rst || (start && !memReq)) begin
      armed <= 1'b0; stall <= 2'd0; havePrev <= 1'b0;
    end else if (memReq && !memValid) begin
      if (!armed) begin
        armed <= 1'b1;
        stall <= (havePrev && prevLow == 8'hFF && memAddr[7:0] == 8'h00) ? 2'd2 : 2'd0;
      end else if (stall != 2'd0) begin
        stall <= stall - 2'd1;
      end else begin
        memValid <= 1'b1;
        memData  <= fdata(memAddr);
        prevLow  <= memAddr[7:0];
        havePrev <= 1'b1;
        armed    <= 1'b0;
      end
    end
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulseStart(input logic [15:0] b);
    @(negedge clk);
    baseAddr = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  // one load; intrude=1 pulses a second start mid-load
  task automatic runLoad(input logic [15:0] b, input bit late, input bit intrude, input string tag);
    int cyc = 0, nv = 0, t6 = -1, t8 = -1, te = -1, td = -1, addrBad = 0, endCnt = 0;
    bit reqAtDone = 1'b1;
    pulseStart(b);
    check(memReq && memAddr == b, "R1 request and base", {47'd0, memReq, memAddr}, {47'd0, 1'b1, b});
    for (int i = 0; i < 200; i++) begin
      if (intrude && i == 4) begin baseAddr = b + 16'h0100; start = 1'b1; end
      if (intrude && i == 5) start = 1'b0;
      @(negedge clk);
      cyc++;
      if (memValid) begin
        nv++;
        if (memAddr != b + 16'(nv - 1)) addrBad++;
        if (nv == 6) t6 = cyc;
        if (nv == 8) t8 = cyc;
      end
      if (endEarly) begin te = cyc; endCnt++; end
      if (done) begin td = cyc; reqAtDone = memReq; break; end
    end
    start = 1'b0;
    check(nv == 8 && addrBad == 0, {tag, " R2 eight bytes in sequence"}, 64'(nv), 64'd8);
    if (late)
      check(te - t6 == 2 && endCnt == 1, {tag, " R5 deferred end"}, 64'(te - t6), 64'd2);
    else
      check(te - t6 == 1 && endCnt == 1, {tag, " R4 end one cycle after sixth"}, 64'(te - t6), 64'd1);
    check(td - t8 == 1 && !reqAtDone, {tag, " R7 done timing"}, 64'(td - t8), 64'd1);
    @(negedge clk);
    check(!done, {tag, " R7 done single pulse"}, 64'(done), 64'd0);
    check(penMap == expMap(b), {tag, " R3 pen map"}, penMap, expMap(b));
  endtask

  task automatic testReset();
    check(penMap == 64'd0 && !done && !memReq && !endEarly, "R9 reset state", penMap, 64'd0);
  endtask

  task automatic testPageFA();
    runLoad(16'h3320, 1'b0, 1'b0, "prime");
    runLoad(16'h21FA, 1'b1, 1'b0, "R6 offset FA");
    check(penMap[63:48] == expMap(16'h21FA)[63:48], "R6 pens 12 to 15",
          {48'd0, penMap[63:48]}, {48'd0, expMap(16'h21FA)[63:48]});
  endtask

  task automatic testMidReset();
    pulseStart(16'h4440);
    repeat (9) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check(penMap == 64'd0 && !memReq && !done, "R9 reset mid-load", penMap, 64'd0);
    repeat (4) @(negedge clk);
    check(!memReq, "R9 idle after reset", 64'(memReq), 64'd0);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    testReset();
    runLoad(16'h1000, 1'b0, 1'b0, "aligned");
    runLoad(16'h7AFC, 1'b0, 1'b0, "break mid");
    runLoad(16'h05FF, 1'b0, 1'b0, "break first");
    testPageFA();
    runLoad(16'h6210, 1'b0, 1'b1, "R8 start ignored");
    testMidReset();
    runLoad(16'hC3F9, 1'b0, 1'b0, "break after fifth");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule